// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Stop Control

This block turns a 32.768 kHz oscillator clock into a once-per-second time base. It does so with a binary ripple-style prescaler of `STAGES` stages and a BCD hours/minutes/seconds counter. The prescaler counts on every oscillator cycle. A seconds step is taken only when the most significant stage goes from 0 to 1. The step is detected against a registered copy of that stage and is also given out as a one-cycle tick strobe.

A stop input freezes timekeeping so software can set a new time. While stopped, every prescaler stage above the lowest `FREE_STAGES` stages is held at zero, and the time counter does not move. The lowest stages keep counting, so the phase at which stop is released is not known from outside. That unknown phase shows up as a small, bounded spread in the delay to the first seconds step after release. After that first step, steps are one full prescaler period apart.

A load strobe writes hours, minutes and seconds in one cycle. It takes effect only while stopped. An asynchronous active-low reset puts everything in its initial state, which is the state the block holds while the oscillator is not running.

Top module: `rtc_presc_clock`

## Requirements
- R1: While reset is low and after it is released, `hh_o`, `mm_o` and `ss_o` read 00 and `tick_o` is 0 until the first seconds step.
- R2: While `stop_i` is 1, `tick_o` stays 0 and the time outputs change only by a load.
- R3: A `load_i` pulse sampled with `stop_i` at 1 places `load_hh_i`, `load_mm_i` and `load_ss_i` on the outputs at the next clock edge. The loaded value holds unchanged for as long as stop stays 1.
- R4: A `load_i` pulse sampled with `stop_i` at 0 has no effect on the time outputs.
- R5: The lowest `FREE_STAGES` prescaler stages count every cycle from reset, stop or not, so at release they hold f = (clock edges since reset) mod 2^FREE_STAGES. With stop_i dropped so that its first 0 sample is at the edge after that phase, `tick_o` first reads 1 exactly 2^(STAGES-1) - f + 1 edges later. That places it within the window from 2^(STAGES-1) - 2^FREE_STAGES + 2 to 2^(STAGES-1) + 1 edges.
- R6: With stop held at 0, consecutive `tick_o` pulses are exactly 2^STAGES clock cycles apart.
- R7: `tick_o` is high for one cycle per step, and `ss_o` shows the incremented second in that same cycle.
- R8: Each output is two BCD digits, with bits [7:4] as tens and [3:0] as ones. Seconds go 59 to 00 and carry one minute; ones digits roll 9 to 0 into the tens digit.
- R9: Minutes go 59 to 00 and carry one hour, and hours go 23 to 00 with no further carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32.768 kHz oscillator clock, drives the lowest prescaler stage |
| rst_ni | input | 1 | asynchronous active-low reset |
| stop_i | input | 1 | 1 freezes time and clears the upper prescaler stages |
| load_i | input | 1 | one-cycle time write strobe, honoured only while stopped |
| load_hh_i | input | 8 | hours to load, BCD |
| load_mm_i | input | 8 | minutes to load, BCD |
| load_ss_i | input | 8 | seconds to load, BCD |
| hh_o | output | 8 | current hours, BCD 00 to 23 |
| mm_o | output | 8 | current minutes, BCD 00 to 59 |
| ss_o | output | 8 | current seconds, BCD 00 to 59 |
| tick_o | output | 1 | one-cycle pulse on each seconds step |

## Verification
The assertions take for granted that any value loaded is a legal BCD time: hours up to 23, minutes and seconds up to 59, each ones digit up to 9. The digit-range and wrap properties rely on that; the block does not repair an illegal load. They also assume `stop_i` and `load_i` change only between clock edges, so that each sample is clean. The stimulus writes only legal times computed from integer seconds, and it drives every input on the falling edge. The release-phase sweep steps through every value of the free-running low stages, so every point of the first-step window is reached.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
  localparam int unsigned NUM_FIELDS = 3;  // 0: seconds, 1: minutes, 2: hours

  typedef logic [7:0] bcd2_t;

  function automatic bcd2_t field_limit(int unsigned idx);
    return (idx == NUM_FIELDS - 1) ? 8'h23 : 8'h59;
  endfunction
endpackage

// File: rtl/rtc_presc_divider.sv
module rtc_presc_divider #(
  parameter int unsigned STAGES      = 15,
  parameter int unsigned FREE_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic msb_o
);
  localparam int unsigned HELD = STAGES - FREE_STAGES;
  localparam logic [FREE_STAGES-1:0] FREE_ONE = FREE_STAGES'(1);

  logic [FREE_STAGES-1:0] free_q;
  logic [HELD-1:0]        held_q;
  logic                   carry;

  assign carry = &free_q;

  // low stages never see stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '0;
    else         free_q <= free_q + FREE_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (stop_i) held_q <= '0;
    else             held_q <= held_q + HELD'(carry);
  end

  assign msb_o = held_q[HELD-1];
endmodule

// File: rtl/rtc_presc_tick.sv
module rtc_presc_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic msb_i,
  output logic step_o,
  output logic tick_o
);
  logic msb_q;
  logic tick_q;

  assign step_o = msb_i & ~msb_q & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      msb_q  <= msb_i;
      tick_q <= step_o;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_presc_bcd_field.sv
module rtc_presc_bcd_field
  import rtc_presc_pkg::*;
#(
  parameter bcd2_t LIMIT = 8'h59
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  inc_i,
  input  logic  load_i,
  input  bcd2_t load_val_i,
  output bcd2_t val_o
);
  bcd2_t val_q;
  bcd2_t val_nxt;

  always_comb begin
    if (val_q == LIMIT)           val_nxt = '0;
    else if (val_q[3:0] == 4'd9)  val_nxt = {val_q[7:4] + 4'd1, 4'd0};
    else                          val_nxt = {val_q[7:4], val_q[3:0] + 4'd1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= val_nxt;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_presc_clock.sv
module rtc_presc_clock
  import rtc_presc_pkg::*;
#(
  parameter int unsigned STAGES      = 15,
  parameter int unsigned FREE_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  logic       load_i,
  input  logic [7:0] load_hh_i,
  input  logic [7:0] load_mm_i,
  input  logic [7:0] load_ss_i,
  output logic [7:0] hh_o,
  output logic [7:0] mm_o,
  output logic [7:0] ss_o,
  output logic       tick_o
);
  logic msb;
  logic step;
  logic load_en;

  logic [NUM_FIELDS-1:0] inc_chain;
  bcd2_t                 load_vals [NUM_FIELDS];
  bcd2_t                 cur       [NUM_FIELDS];

  assign load_en = load_i & stop_i;

  rtc_presc_divider #(
    .STAGES     (STAGES),
    .FREE_STAGES(FREE_STAGES)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(stop_i),
    .msb_o (msb)
  );

  rtc_presc_tick u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(stop_i),
    .msb_i (msb),
    .step_o(step),
    .tick_o(tick_o)
  );

  assign load_vals[0] = load_ss_i;
  assign load_vals[1] = load_mm_i;
  assign load_vals[2] = load_hh_i;
  assign inc_chain[0] = step;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    rtc_presc_bcd_field #(
      .LIMIT(field_limit(i))
    ) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc_chain[i]),
      .load_i    (load_en),
      .load_val_i(load_vals[i]),
      .val_o     (cur[i])
    );
    if (i < NUM_FIELDS - 1) begin : g_carry
      assign inc_chain[i+1] = inc_chain[i] & (cur[i] == field_limit(i));
    end
  end

  assign ss_o = cur[0];
  assign mm_o = cur[1];
  assign hh_o = cur[2];
endmodule

// File: rtl/rtc_presc_checker.sv
module rtc_presc_checker #(
  parameter int unsigned STAGES = 15
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       load_i,
  input logic [7:0] load_hh_i,
  input logic [7:0] load_mm_i,
  input logic [7:0] load_ss_i,
  input logic [7:0] hh_o,
  input logic [7:0] mm_o,
  input logic [7:0] ss_o,
  input logic       tick_o
);
  localparam int unsigned GAP_W = STAGES + 2;
  localparam logic [GAP_W-1:0] PERIOD = GAP_W'(1) << STAGES;

  logic [GAP_W-1:0] gap_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      gap_q   <= tick_o ? GAP_W'(1) : gap_q + GAP_W'(1);
      armed_q <= stop_i ? 1'b0 : (tick_o ? 1'b1 : armed_q);
    end
  end

  p_no_tick_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !tick_o);

  // R2 and R4: without an honoured load, time moves only with a tick
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_i && load_i) |=> (tick_o || $stable({hh_o, mm_o, ss_o})));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && load_i) |=> (hh_o == $past(load_hh_i) && mm_o == $past(load_mm_i)
                            && ss_o == $past(load_ss_i)));

  p_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && armed_q) |-> (gap_q == PERIOD));

  p_tick_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  p_bcd_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_o[3:0] <= 4'd9 && mm_o[3:0] <= 4'd9 && hh_o[3:0] <= 4'd9 &&
     ss_o <= 8'h59 && mm_o <= 8'h59 && hh_o <= 8'h23));

  p_sec_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(ss_o) == 8'h59) |-> (ss_o == 8'h00 && mm_o != $past(mm_o)));

  p_day_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(ss_o) == 8'h59 && $past(mm_o) == 8'h59 && $past(hh_o) == 8'h23)
      |-> (hh_o == 8'h00 && mm_o == 8'h00 && ss_o == 8'h00));
endmodule

bind rtc_presc_clock rtc_presc_checker #(.STAGES(STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stop_i   (stop_i),
  .load_i   (load_i),
  .load_hh_i(load_hh_i),
  .load_mm_i(load_mm_i),
  .load_ss_i(load_ss_i),
  .hh_o     (hh_o),
  .mm_o     (mm_o),
  .ss_o     (ss_o),
  .tick_o   (tick_o)
);

// File: tb/tb_rtc_presc_clock.sv
module tb_rtc_presc_clock;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 6;
  localparam int FREE       = 2;
  localparam int HALF       = 1 << (STAGES - 1);
  localparam int FULL       = 1 << STAGES;
  localparam int FREE_MOD   = 1 << FREE;
  localparam int DAY        = 86400;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       stop_i;
  logic       load_i;
  logic [7:0] load_hh_i, load_mm_i, load_ss_i;
  logic [7:0] hh_o, mm_o, ss_o;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  rtc_presc_clock #(.STAGES(STAGES), .FREE_STAGES(FREE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop_i), .load_i(load_i),
    .load_hh_i(load_hh_i), .load_mm_i(load_mm_i), .load_ss_i(load_ss_i),
    .hh_o(hh_o), .mm_o(mm_o), .ss_o(ss_o), .tick_o(tick_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle_();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  task automatic check_tod(input string req, input int secs);
    int h = secs / 3600;
    int m = (secs / 60) % 60;
    int s = secs % 60;
    chk(hh_o == bcd(h), req, "hours", int'(hh_o), int'(bcd(h)));
    chk(mm_o == bcd(m), req, "minutes", int'(mm_o), int'(bcd(m)));
    chk(ss_o == bcd(s), req, "seconds", int'(ss_o), int'(bcd(s)));
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      cycle_();
      n++;
    end while (!tick_o && n < 4 * FULL);
  endtask

  task automatic load_time(input int secs);
    load_hh_i = bcd(secs / 3600);
    load_mm_i = bcd((secs / 60) % 60);
    load_ss_i = bcd(secs % 60);
    load_i    = 1'b1;
    cycle_();
    load_i    = 1'b0;
  endtask

  task automatic run_from(input int base, input int nticks, input string req);
    int n;
    stop_i = 1'b1;
    cycle_();
    load_time(base);
    check_tod("R3", base);
    stop_i = 1'b0;
    for (int k = 1; k <= nticks; k++) begin
      wait_tick(n);
      check_tod(req, (base + k) % DAY);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, f, ticks_seen;
    bit moved;
    rst_ni = 1'b0; stop_i = 1'b1; load_i = 1'b0;
    load_hh_i = '0; load_mm_i = '0; load_ss_i = '0;
    repeat (3) @(negedge clk);
    check_tod("R1", 0);
    chk(tick_o == 1'b0, "R1", "tick in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    cycle_();
    check_tod("R1", 0);

    // R2: stopped, nothing moves
    ticks_seen = 0; moved = 0;
    for (int i = 0; i < 3 * FULL; i++) begin
      cycle_();
      if (tick_o) ticks_seen++;
      if (hh_o != 0 || mm_o != 0 || ss_o != 0) moved = 1;
    end
    chk(ticks_seen == 0, "R2", "ticks while stopped", ticks_seen, 0);
    chk(!moved, "R2", "time moved while stopped", int'(moved), 0);

    // R3: load while stopped, holds
    load_time(12 * 3600 + 34 * 60 + 56);
    check_tod("R3", 12 * 3600 + 34 * 60 + 56);
    ticks_seen = 0;
    for (int i = 0; i < 2 * FULL; i++) begin
      cycle_();
      if (tick_o) ticks_seen++;
    end
    check_tod("R3", 12 * 3600 + 34 * 60 + 56);
    chk(ticks_seen == 0, "R2", "ticks while loaded and stopped", ticks_seen, 0);

    // R5: every release phase of the free stages
    for (int ph = 0; ph < FREE_MOD; ph++) begin
      stop_i = 1'b1;
      cycle_();
      load_time(8 * 3600);
      while ((cyc % FREE_MOD) != ph) cycle_();
      f = cyc % FREE_MOD;
      stop_i = 1'b0;
      wait_tick(n);
      chk(n == HALF - f + 1, "R5", "edges to first tick", n, HALF - f + 1);
      chk(n >= HALF - FREE_MOD + 2 && n <= HALF + 1, "R5", "first tick window", n, HALF);
      check_tod("R7", 8 * 3600 + 1);
      cycle_();
      chk(tick_o == 1'b0, "R7", "tick width", int'(tick_o), 0);
      wait_tick(n);
      chk(n == FULL - 1, "R6", "tick spacing", n + 1, FULL);
      check_tod("R6", 8 * 3600 + 2);
      // R4: load with stop low is ignored
      repeat (3) cycle_();
      load_time(11 * 3600 + 11 * 60 + 11);
      check_tod("R4", 8 * 3600 + 2);
      repeat (2) cycle_();
      check_tod("R4", 8 * 3600 + 2);
    end

    run_from(58, 3, "R8");
    run_from(9 * 3600 + 59 * 60 + 58, 3, "R9");
    run_from(23 * 3600 + 59 * 60 + 57, 4, "R9");
    run_from(58 * 60 + 30, 1300, "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule